// File: doc/BRIEF.md
# Warp Memory Access Coalescer

This block takes one warp-wide memory request at a time. The request carries one address per thread, a per-thread active mask, one access size shared by all threads and the access kind (load, store or atomic). The block sorts the active threads into 128-byte lines and issues one downstream line request per cycle. Each request carries the line number and the mask of the threads that it serves. After the last line it raises a one-cycle done pulse.

Same-address loads are served by one fetch shared by every thread that asks for it, so their threads all appear in the mask. For same-address stores, only the lowest-indexed active thread appears in the mask. Atomics are grouped like loads, and a line is flagged when two threads in its mask target the same address, so that a later stage can serialize them. Addresses are assumed to be aligned to the access size, so no access crosses a line.

The block accepts a new warp only when it is idle. A warp that touches L distinct lines occupies it for L+1 cycles.

Top module: `warp_coalescer`

## Requirements
- R1: After reset, req_ready is 1, and line_valid, line_atomic_dup and warp_done are 0.
- R2: A warp is accepted on a clock edge where req_valid and req_ready are both 1. From the next cycle, req_ready is 0 until the cycle after warp_done. Requests presented while req_ready is 0 are ignored.
- R3: A thread whose req_mask bit is 0 never appears in any line_mask. A warp with no active thread produces no line and raises warp_done in the first cycle after acceptance.
- R4: The block issues exactly one line request per distinct 128-byte line touched by active threads. line_addr is the address with its low 7 bits dropped. Line requests come in consecutive cycles, starting with the first cycle after acceptance.
- R5: Lines are issued in increasing order of the lowest-indexed active thread that touches each line, whatever the address order.
- R6: For a load (req_kind 0), line_mask holds every active thread whose address falls in that line, including threads that share an address.
- R7: For a store (req_kind 1), line_mask holds, for each distinct address in the line, only the lowest-indexed active thread with that address.
- R8: For an atomic (req_kind 2), line_mask is formed as for a load. line_atomic_dup is 1 exactly when two threads in that mask share an address. For loads and stores it is always 0.
- R9: warp_done is high for exactly one cycle, the cycle after the last line. line_valid is 0 in that cycle.
- R10: req_size encodes 1, 2, 4, 8 or 16 bytes as values 0 to 4. It does not change the grouping of aligned addresses. Every active address must be a multiple of the access size.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Warp request present |
| req_ready | output | 1 | Block idle, can accept a warp |
| req_kind | input | 2 | 0 load, 1 store, 2 atomic |
| req_size | input | 3 | Access size code, 0..4 for 1..16 bytes |
| req_mask | input | 32 | Per-thread active bits |
| req_addr | input | 1024 | Thread t byte address at bits [32t+31:32t] |
| line_valid | output | 1 | A line request is present this cycle |
| line_addr | output | 25 | Line number (address bits 31..7) |
| line_mask | output | 32 | Threads served by this line request |
| line_atomic_dup | output | 1 | Atomic line with a same-address conflict |
| warp_done | output | 1 | One-cycle pulse after the last line |

## Verification
The outputs are driven from state registers with no further pipeline stage. The k-th line of a warp (counting from zero) is therefore due in cycle k+1 after the accepting edge, and done follows in cycle L+1 for a warp of L lines. req_ready comes back one cycle after that. The bench drives inputs on the falling edge and samples each of these outputs on the falling edge of exactly the cycle it is due. A separate reference list, built from the grouping, ordering and winner rules, gives the expected line for each of those cycles, so that a missing, extra or reordered line is caught at the exact cycle where it differs.

// File: rtl/wc_pkg.sv
// Shared types for the warp coalescer.
package wc_pkg;
    // Access kind carried with each warp request.
    typedef enum logic [1:0] {
        WC_LOAD   = 2'd0,
        WC_STORE  = 2'd1,
        WC_ATOMIC = 2'd2,
        WC_RSVD   = 2'd3
    } wc_kind_e;

    // Largest legal size code (16 bytes).
    localparam int WC_MAX_SIZE_CODE = 4;
endpackage

// File: rtl/wc_leader.sv
// Finds the lowest-indexed set bit of a pending-thread vector.
// Assumes nothing about the input; found is 0 when the vector is empty.
module wc_leader #(
    parameter int NUM_THREADS = 32,
    localparam int TID_W = $clog2(NUM_THREADS)
) (
    input  logic [NUM_THREADS-1:0] pend,
    output logic                   found,
    output logic [TID_W-1:0]       idx
);
    // Scan from the top down so the lowest set bit wins.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int t = NUM_THREADS - 1; t >= 0; t--) begin
            if (pend[t]) begin
                found = 1'b1;
                idx   = TID_W'(t);
            end
        end
    end
endmodule

// File: rtl/wc_line_match.sv
// Marks every pending thread whose address lies in a given line.
// Assumes addresses are aligned, so the line is set by the upper bits alone.
module wc_line_match #(
    parameter int NUM_THREADS = 32,
    parameter int ADDR_W      = 32,
    parameter int LINE_SHIFT  = 7,
    localparam int LINE_W = ADDR_W - LINE_SHIFT
) (
    input  logic [NUM_THREADS*ADDR_W-1:0] addrs,
    input  logic [NUM_THREADS-1:0]        pend,
    input  logic [LINE_W-1:0]             key,
    output logic [NUM_THREADS-1:0]        match
);
    // One line comparator per thread.
    for (genvar t = 0; t < NUM_THREADS; t++) begin : g_cmp
        assign match[t] = pend[t] &&
                          (addrs[t*ADDR_W+LINE_SHIFT +: LINE_W] == key);
    end
endmodule

// File: rtl/wc_dedup.sv
// Flags each selected thread that has a lower-indexed selected thread
// with the identical full address. Used for the store winner and atomic conflicts.
module wc_dedup #(
    parameter int NUM_THREADS = 32,
    parameter int ADDR_W      = 32
) (
    input  logic [NUM_THREADS*ADDR_W-1:0] addrs,
    input  logic [NUM_THREADS-1:0]        sel,
    output logic [NUM_THREADS-1:0]        dup_lower
);
    // Triangular compare: thread i against every thread j below it.
    always_comb begin
        dup_lower = '0;
        for (int i = 1; i < NUM_THREADS; i++) begin
            for (int j = 0; j < i; j++) begin
                if (sel[i] && sel[j] &&
                    addrs[i*ADDR_W +: ADDR_W] == addrs[j*ADDR_W +: ADDR_W])
                    dup_lower[i] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/warp_coalescer.sv
// Warp memory access coalescer.
// Accepts one warp request when idle and emits one 128-byte line request per
// cycle, ordered by the lowest thread touching each line, then a done pulse.
// Assumes every active address is aligned to the access size.
module warp_coalescer
    import wc_pkg::*;
#(
    parameter int NUM_THREADS = 32,
    parameter int ADDR_W      = 32,
    parameter int LINE_BYTES  = 128,
    localparam int LINE_SHIFT = $clog2(LINE_BYTES),
    localparam int LINE_W     = ADDR_W - LINE_SHIFT,
    localparam int TID_W      = $clog2(NUM_THREADS)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          req_valid,
    output logic                          req_ready,
    input  logic [1:0]                    req_kind,
    input  logic [2:0]                    req_size,
    input  logic [NUM_THREADS-1:0]        req_mask,
    input  logic [NUM_THREADS*ADDR_W-1:0] req_addr,
    output logic                          line_valid,
    output logic [LINE_W-1:0]             line_addr,
    output logic [NUM_THREADS-1:0]        line_mask,
    output logic                          line_atomic_dup,
    output logic                          warp_done
);
    logic                          busy_q;
    logic [NUM_THREADS-1:0]        pend_q;
    logic [NUM_THREADS*ADDR_W-1:0] addr_q;
    wc_kind_e                      kind_q;

    logic                   accept;
    logic                   lead_found;
    logic [TID_W-1:0]       lead_idx;
    logic [LINE_W-1:0]      lead_line;
    logic [NUM_THREADS-1:0] match;
    logic [NUM_THREADS-1:0] dup_lower;

    assign req_ready = !busy_q;
    assign accept    = req_valid && !busy_q;

    // Warp capture and pending-thread retirement.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            pend_q <= '0;
            addr_q <= '0;
            kind_q <= WC_LOAD;
        end else if (accept) begin
            busy_q <= 1'b1;
            pend_q <= req_mask;
            addr_q <= req_addr;
            kind_q <= wc_kind_e'(req_kind);
        end else if (busy_q) begin
            if (lead_found) pend_q <= pend_q & ~match;
            else            busy_q <= 1'b0;
        end
    end

    wc_leader #(.NUM_THREADS(NUM_THREADS)) leader_i (
        .pend  (pend_q),
        .found (lead_found),
        .idx   (lead_idx)
    );

    // Line of the leading pending thread.
    assign lead_line = addr_q[int'(lead_idx)*ADDR_W+LINE_SHIFT +: LINE_W];

    wc_line_match #(
        .NUM_THREADS(NUM_THREADS), .ADDR_W(ADDR_W), .LINE_SHIFT(LINE_SHIFT)
    ) match_i (
        .addrs (addr_q),
        .pend  (pend_q),
        .key   (lead_line),
        .match (match)
    );

    wc_dedup #(.NUM_THREADS(NUM_THREADS), .ADDR_W(ADDR_W)) dedup_i (
        .addrs     (addr_q),
        .sel       (match),
        .dup_lower (dup_lower)
    );

    // Output request formation per access kind.
    always_comb begin
        line_valid      = busy_q && lead_found;
        line_addr       = lead_line;
        line_mask       = (kind_q == WC_STORE) ? (match & ~dup_lower) : match;
        line_atomic_dup = line_valid && (kind_q == WC_ATOMIC) && (|dup_lower);
        warp_done       = busy_q && !lead_found;
    end

    // Alignment check of the incoming warp (assertion support only).
    logic                misalign;
    logic [ADDR_W-1:0]   align_bits;
    always_comb begin
        align_bits = (ADDR_W'(1) << req_size) - ADDR_W'(1);
        misalign   = 1'b0;
        for (int t = 0; t < NUM_THREADS; t++)
            if (req_mask[t] && ((req_addr[t*ADDR_W +: ADDR_W] & align_bits) != '0))
                misalign = 1'b1;
    end

    a_r10_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        accept |-> (!misalign && int'(req_size) <= WC_MAX_SIZE_CODE));
    a_r2_ready_drops: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !req_ready);
    a_r3_only_active: assert property (@(posedge clk) disable iff (!rst_n)
        line_valid |-> ((line_mask & ~pend_q) == '0));
    a_r4_disjoint_lines: assert property (@(posedge clk) disable iff (!rst_n)
        (line_valid && $past(line_valid)) |-> ((line_mask & $past(line_mask)) == '0));
    a_r7_mask_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
        line_valid |-> (line_mask != '0));
    a_r8_dup_atomic_only: assert property (@(posedge clk) disable iff (!rst_n)
        line_atomic_dup |-> (kind_q == WC_ATOMIC));
    a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        warp_done |=> (!warp_done && req_ready));
    a_r9_done_no_line: assert property (@(posedge clk) disable iff (!rst_n)
        warp_done |-> !line_valid);
endmodule

// File: tb/warp_coalescer_tb.sv
module warp_coalescer_tb_top;
    localparam int N  = 32;
    localparam int AW = 32;

    typedef struct packed {
        logic [1:0]  kind;
        logic [2:0]  size;
        logic [31:0] base;
        logic [31:0] stride;
        logic [5:0]  modv;
        logic [31:0] mask;
    } vec_t;

    localparam int NV = 11;
    // Thread t address = base + (t % modv) * stride.
    localparam vec_t VEC [NV] = '{
        '{2'd0, 3'd3, 32'h40,    32'd8,          6'd32, 32'h0000FFFF}, // two lines (R4)
        '{2'd0, 3'd2, 32'h1000,  32'd4,          6'd32, 32'hFFFFFFFF}, // one full line
        '{2'd0, 3'd2, 32'h2040,  32'd0,          6'd1,  32'hF0F0F0F0}, // broadcast (R6)
        '{2'd1, 3'd2, 32'h3000,  32'd4,          6'd4,  32'hFFFFFFFF}, // store winners (R7)
        '{2'd1, 3'd2, 32'h3000,  32'd4,          6'd4,  32'hFFFFFFFE}, // winners skip t0 (R7)
        '{2'd2, 3'd2, 32'h4000,  32'd4,          6'd8,  32'hFFFFFFFF}, // atomic conflict (R8)
        '{2'd2, 3'd2, 32'h4000,  32'd4,          6'd32, 32'hFFFFFFFF}, // atomic clean (R8)
        '{2'd0, 3'd3, 32'h5000,  32'd128,        6'd32, 32'h000000FF}, // eight lines
        '{2'd0, 3'd4, 32'h40,    32'd16,         6'd32, 32'hFFFFFFFF}, // 16B, five lines
        '{2'd0, 3'd0, 32'h1000,  32'd4,          6'd32, 32'hFFFFFFFF}, // size code 0 (R10)
        '{2'd0, 3'd2, 32'h10000, 32'hFFFFFF80,   6'd32, 32'h0000000F}  // descending (R5)
    };

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           req_valid = 1'b0;
    logic           req_ready;
    logic [1:0]     req_kind = '0;
    logic [2:0]     req_size = '0;
    logic [N-1:0]   req_mask = '0;
    logic [N*AW-1:0] req_addr = '0;
    logic           line_valid;
    logic [24:0]    line_addr;
    logic [N-1:0]   line_mask;
    logic           line_atomic_dup;
    logic           warp_done;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;
    logic [31:0] a [N];

    always #2 clk = ~clk; // 250 MHz

    warp_coalescer dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_kind(req_kind), .req_size(req_size), .req_mask(req_mask),
        .req_addr(req_addr), .line_valid(line_valid), .line_addr(line_addr),
        .line_mask(line_mask), .line_atomic_dup(line_atomic_dup),
        .warp_done(warp_done)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Drive one warp from a[] and check each line against a model of R4..R9.
    // When hold is set, req_valid stays high with another mask while busy (R2).
    task automatic run_warp(input logic [1:0] kind, input logic [2:0] size,
                            input logic [N-1:0] mask, input bit hold);
        logic [N-1:0] pend, m, em;
        logic [24:0]  ln;
        bit           dup;
        int           lead;
        string        tag;
        tag = (kind == 2'd1) ? "R7" : (kind == 2'd2) ? "R8" : "R6";
        @(negedge clk);
        chk(req_ready == 1'b1, "R2", "ready before accept", 64'(req_ready), 64'd1);
        req_valid = 1'b1;
        req_kind  = kind;
        req_size  = size;
        req_mask  = mask;
        for (int t = 0; t < N; t++) req_addr[t*AW +: AW] = a[t];
        pend = mask;
        @(negedge clk);
        if (hold) req_mask = ~mask; else req_valid = 1'b0;
        while (pend != '0) begin
            lead = -1;
            for (int t = N - 1; t >= 0; t--) if (pend[t]) lead = t;
            ln = a[lead][31:7];
            m  = '0;
            for (int t = 0; t < N; t++) if (pend[t] && a[t][31:7] == ln) m[t] = 1'b1;
            em  = m;
            dup = 1'b0;
            for (int t = 0; t < N; t++)
                for (int j = 0; j < t; j++)
                    if (m[t] && m[j] && a[t] == a[j]) begin
                        if (kind == 2'd1) em[t] = 1'b0;
                        if (kind == 2'd2) dup = 1'b1;
                    end
            pend = pend & ~m;
            chk(line_valid == 1'b1, "R4", "line_valid", 64'(line_valid), 64'd1);
            chk(line_addr == ln, "R5", "line_addr order", 64'(line_addr), 64'(ln));
            chk(line_mask == em, tag, "line_mask", 64'(line_mask), 64'(em));
            chk(line_atomic_dup == dup, "R8", "atomic dup flag",
                64'(line_atomic_dup), 64'(dup));
            chk(req_ready == 1'b0, "R2", "ready while busy", 64'(req_ready), 64'd0);
            @(negedge clk);
        end
        chk(warp_done == 1'b1 && line_valid == 1'b0, "R9", "done after last line",
            64'({warp_done, line_valid}), 64'b10);
        req_valid = 1'b0;
        @(negedge clk);
        chk(warp_done == 1'b0 && req_ready == 1'b1, "R9", "done single, ready back",
            64'({warp_done, req_ready}), 64'b01);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: state under and after reset
        chk(req_ready && !line_valid && !warp_done && !line_atomic_dup, "R1",
            "reset outputs", 64'({req_ready, line_valid, warp_done, line_atomic_dup}),
            64'b1000);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready && !line_valid && !warp_done, "R1", "after reset",
            64'({req_ready, line_valid, warp_done}), 64'b100);

        for (int v = 0; v < NV; v++) begin
            for (int t = 0; t < N; t++)
                a[t] = VEC[v].base + 32'(t % int'(VEC[v].modv)) * VEC[v].stride;
            run_warp(VEC[v].kind, VEC[v].size, VEC[v].mask, 1'b0);
        end

        // R3: no active thread gives done only
        for (int t = 0; t < N; t++) a[t] = 32'h100 * 32'(t);
        run_warp(2'd0, 3'd2, '0, 1'b0);

        // R3: sparse mask, inactive threads on their own lines must not show
        run_warp(2'd0, 3'd2, 32'h80000001, 1'b0);

        // R2: request held while busy is ignored
        for (int t = 0; t < N; t++) a[t] = 32'h6000 + 32'd128 * 32'(t % 3);
        run_warp(2'd1, 3'd2, 32'h0000003F, 1'b1);

        // R10: same addresses, size 16B vs 4B give same lines
        for (int t = 0; t < N; t++) a[t] = 32'h7000 + 32'd16 * 32'(t);
        run_warp(2'd0, 3'd4, 32'hFFFFFFFF, 1'b0);
        run_warp(2'd0, 3'd2, 32'hFFFFFFFF, 1'b0);

        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule